// File: doc/BRIEF.md
# Serial Command Port with Write Lock

This block sits between an SPI master and a chip's register file. Each chip-select frame carries exactly one 32-bit command word. The block turns that word into a single read or write strobe on a plain register port. The answer to a read travels back in the frame that follows, shifted out MSB first. Every write goes through a lock first. Writes to the register file are dropped until a two-word key has been written to the lock register. The lock can be closed again at any time.

The SPI pins are brought into the system clock domain through synchronizers, so the SPI clock must be several times slower than the system clock. The register file is outside this block. It sees a registered address and write data, a one-cycle write strobe and a one-cycle read strobe. It returns read data a fixed number of cycles after the read strobe. Two addresses are served inside the block: the lock register and a read-only revision word.

Top module: `spi_reg_bridge`

## Requirements
- R1: A command word has the write flag in bit 31 (1 = write, 0 = read), the 7-bit address in bits 30..24 and the write data in bits 15..0. A read of an external address gives one `reg_re` pulse. A write to an external address while unlocked gives one `reg_we` pulse. The strobe carries `reg_addr` and `reg_wdata` from the word. The two strobes never occur together.
- R2: A command with any of bits 23..16 set is discarded. It causes no strobe and no lock change, and the next response is zero.
- R3: While the lock state is not 3, a write to an external address produces no `reg_we`.
- R4: Reading address 0x00 returns the lock state in bits 1..0: 0 = locked, 1 = first key seen, 3 = open. The state after reset is 0.
- R5: Writing 0xA569 to address 0x00 sets the lock state to 1 from any state.
- R6: Writing 0x1248 to address 0x00 in state 1 gives state 3. Any other write to address 0x00 gives state 0, and this includes 0x0000 written in state 3.
- R7: Address 0x7F reads as the REVISION parameter. Writes to 0x7F never produce `reg_we` and do not change what it reads.
- R8: The frame after a command returns 32 bits, MSB first. Bits 31..16 are zero. Bits 15..0 hold the read result, or zero if the command was a write or was discarded. For an external read, the result is the `reg_rdata` value present READ_LATENCY+1 cycles after `reg_re` goes high.
- R9: `spi_miso` is 0 whenever chip select is deasserted (after the synchronizer delay). After reset it is 0.
- R10: A frame that ends with a bit count other than 32 is ignored. It causes no strobe and no lock change, and the pending response stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock, mode 0, idle low |
| spi_cs_n | input | 1 | Chip select, active low, one command per assertion |
| spi_mosi | input | 1 | Command data, sampled on the rising SPI clock |
| spi_miso | output | 1 | Response data, changes after the falling SPI clock |
| reg_addr | output | 7 | Register address toward the register file |
| reg_wdata | output | 16 | Write data toward the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data from the register file |

## Verification
The case that overlaps is a read command followed by the next frame after the shortest chip-select gap. The external read data reaches the response register while the new frame is already selected but has not yet had its first clock edge. The bench provokes this with three-cycle gaps after read commands, both in directed steps and in the random mix. It judges the case by comparing the first bits shifted out in the following frame with the value its own register model predicts. A second overlap comes from unlock steps placed right before writes and reads. There the bench checks the lock state and the write strobe count against its own model of the key sequence.

// File: rtl/spi_gate_pkg.sv
package spi_gate_pkg;
  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 16;
  localparam int RSV_W      = 8;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd3
  } lock_state_e;

  // field order is the wire format of a command word
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [RSV_W-1:0]  rsv;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_frame_port.sv
module spi_frame_port #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic                  miso,
  output logic                  active,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic rise, fall, started;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sclk_s = sclk_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign active = ~cs_s;
  assign rise   = active & sclk_s & ~sclk_d;
  assign fall   = active & ~sclk_s & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      cs_d        <= 1'b1;
      cnt         <= '0;
      started     <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      miso        <= 1'b0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      sclk_d      <= sclk_s;
      cs_d        <= cs_s;
      frame_valid <= 1'b0;
      if (!active) begin
        cnt     <= '0;
        started <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
        if (fall) started <= 1'b1;
      end
      // end of frame: only an exact bit count yields a command
      if (cs_s && !cs_d && cnt == CNT_FULL) begin
        frame_valid <= 1'b1;
        frame_word  <= rx_sh;
      end
      // response tracks the holding word until the first falling edge
      if (fall)          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      else if (!started) tx_sh <= tx_word;
      miso <= active ? tx_sh[FRAME_BITS-1] : 1'b0;
    end
  end
endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
  import spi_gate_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hA569,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h1248
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output lock_state_e       state
);
  lock_state_e nxt;

  always_comb begin
    nxt = state;
    if (wr_en) begin
      if (wr_data == KEY_FIRST)                         nxt = LK_HALF;
      else if (state == LK_HALF && wr_data == KEY_SECOND) nxt = LK_OPEN;
      else                                              nxt = LK_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LK_LOCKED;
    else     state <= nxt;
  end
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_gate_pkg::*;
#(
  parameter int                SYNC_STAGES  = 2,
  parameter int                READ_LATENCY = 1,
  parameter logic [15:0]       REVISION     = 16'h0107,
  parameter logic [15:0]       KEY_FIRST    = 16'hA569,
  parameter logic [15:0]       KEY_SECOND   = 16'h1248,
  parameter logic [6:0]        LOCK_ADDR    = 7'h00,
  parameter logic [6:0]        REV_ADDR     = 7'h7F
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [6:0]  reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  output logic        reg_re,
  input  logic [15:0] reg_rdata
);
  localparam int PAD_W = FRAME_BITS - DATA_W;

  logic                  frame_active, frame_valid;
  logic [FRAME_BITS-1:0] frame_word;
  logic [DATA_W-1:0]     resp_q;
  cmd_t                  cmd;
  lock_state_e           lock_state;
  logic                  cmd_ok, is_lock, is_rev, is_ext;
  logic                  lock_wr, we_nxt, re_nxt;
  logic [READ_LATENCY:0] rd_pipe;

  spi_frame_port #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)) u_port (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word({{PAD_W{1'b0}}, resp_q}), .miso(spi_miso), .active(frame_active),
    .frame_valid(frame_valid), .frame_word(frame_word)
  );

  assign cmd     = cmd_t'(frame_word);
  assign cmd_ok  = frame_valid && (cmd.rsv == '0);
  assign is_lock = (cmd.addr == LOCK_ADDR);
  assign is_rev  = (cmd.addr == REV_ADDR);
  assign is_ext  = !is_lock && !is_rev;
  assign lock_wr = cmd_ok && cmd.wr && is_lock;
  assign we_nxt  = cmd_ok && cmd.wr && is_ext && (lock_state == LK_OPEN);
  assign re_nxt  = cmd_ok && !cmd.wr && is_ext;

  unlock_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_lock (
    .clk(clk), .rst(rst), .wr_en(lock_wr), .wr_data(cmd.data), .state(lock_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_pipe   <= '0;
    end else begin
      reg_we  <= we_nxt;
      reg_re  <= re_nxt;
      rd_pipe <= {rd_pipe[READ_LATENCY-1:0], re_nxt};
      if (cmd_ok) begin
        reg_addr  <= cmd.addr;
        reg_wdata <= cmd.data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= '0;
    end else if (rd_pipe[READ_LATENCY]) begin
      resp_q <= reg_rdata;
    end else if (frame_valid) begin
      if (!cmd_ok || cmd.wr) resp_q <= '0;
      else if (is_lock)      resp_q <= {{(DATA_W-2){1'b0}}, lock_state};
      else if (is_rev)       resp_q <= REVISION;
    end
  end
endmodule

// File: rtl/reg_bridge_checker.sv
module reg_bridge_checker #(
  parameter logic [15:0] KEY_FIRST = 16'hA569,
  parameter logic [6:0]  LOCK_ADDR = 7'h00,
  parameter logic [6:0]  REV_ADDR  = 7'h7F
) (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic        reg_re,
  input logic [6:0]  reg_addr,
  input logic        spi_miso,
  input logic        act,
  input logic        fv,
  input logic [31:0] fw,
  input logic [1:0]  lock_state
);
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(reg_we && reg_re)); // R1
  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we); // R1
  AST_WE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst) reg_we |-> lock_state == 2'd3); // R3
  AST_WE_EXTERNAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_addr != LOCK_ADDR && reg_addr != REV_ADDR)); // R7
  AST_LOCK_ENCODING: assert property (@(posedge clk) disable iff (rst) lock_state != 2'd2); // R4
  AST_FIRST_KEY: assert property (@(posedge clk) disable iff (rst)
    (fv && fw[31] && fw[30:24] == LOCK_ADDR && fw[23:16] == 8'h00 && fw[15:0] == KEY_FIRST)
    |=> lock_state == 2'd1); // R5
  AST_RSV_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (fv && fw[23:16] != 8'h00) |=> (!reg_we && !reg_re && $stable(lock_state))); // R2
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst) !act |=> !spi_miso); // R9
endmodule

bind spi_reg_bridge reg_bridge_checker #(
  .KEY_FIRST(KEY_FIRST), .LOCK_ADDR(LOCK_ADDR), .REV_ADDR(REV_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
  .spi_miso(spi_miso), .act(frame_active), .fv(frame_valid), .fw(frame_word),
  .lock_state(lock_state)
);

// File: tb/test_spi_reg_bridge.sv
module test_spi_reg_bridge;
  localparam int HALF  = 8;
  localparam int SETUP = 16;
  localparam logic [15:0] REV = 16'h0107;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic spi_miso, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  logic [15:0] rf_mem [128];
  logic [15:0] exp_mem [128];
  logic [15:0] exp_resp = '0;
  logic [1:0]  exp_state = 2'd0;
  int we_count = 0, we_base = 0, pend_we = 0;
  string pend_tag = "";
  bit pend_valid = 0;

  always #2.5 clk = ~clk;

  spi_reg_bridge i_spi_reg_bridge (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(spi_miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // register file model with one cycle of read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) rf_mem[i] <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) rf_mem[reg_addr] <= reg_wdata;
      if (reg_re) reg_rdata <= rf_mem[reg_addr];
    end
  end

  always_ff @(posedge clk) if (!rst && reg_we) we_count <= we_count + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit wr, input logic [6:0] a, input logic [15:0] d);
    return {wr, a, 8'h00, d};
  endfunction

  task automatic model(input logic [31:0] c, output int we_exp, output string tag);
    logic wr = c[31];
    logic [6:0] a = c[30:24];
    logic [15:0] d = c[15:0];
    we_exp = 0;
    if (c[23:16] != 8'h00) begin
      exp_resp = '0; tag = "R2";
    end else if (wr) begin
      exp_resp = '0;
      if (a == 7'h00) begin
        tag = (d == 16'hA569) ? "R5" : "R6";
        if (d == 16'hA569) exp_state = 2'd1;
        else if (exp_state == 2'd1 && d == 16'h1248) exp_state = 2'd3;
        else exp_state = 2'd0;
      end else if (a == 7'h7F) begin
        tag = "R7";
      end else if (exp_state == 2'd3) begin
        exp_mem[a] = d; we_exp = 1; tag = "R1";
      end else begin
        tag = "R3";
      end
    end else begin
      if (a == 7'h00)      begin exp_resp = {14'h0, exp_state}; tag = "R4"; end
      else if (a == 7'h7F) begin exp_resp = REV; tag = "R7"; end
      else                 begin exp_resp = exp_mem[a]; tag = "R8"; end
    end
  endtask

  task automatic frame(input logic [31:0] cmd, input int nbits, input int gap);
    logic [31:0] rx = '0;
    int we_exp;
    string tag;
    @(negedge clk) cs_n = 1'b0;
    repeat (SETUP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[31-i];
      repeat (HALF) @(negedge clk);
      if (i == 0) begin
        if (pend_valid) chk({pend_tag, " write strobes"}, we_count - we_base, pend_we);
        we_base = we_count;
      end
      rx = {rx[30:0], spi_miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    if (nbits == 32) begin
      chk("R8 response", rx, {16'h0, exp_resp});
      model(cmd, we_exp, tag);
      pend_we = we_exp; pend_tag = tag;
    end else begin
      pend_we = 0; pend_tag = "R10";
    end
    pend_valid = 1;
    repeat (gap) @(negedge clk);
    if (gap >= 8) chk("R9 idle miso", {31'h0, spi_miso}, 32'h0);
  endtask

  function automatic logic [31:0] rand_cmd();
    int s = $urandom_range(0, 99);
    logic [6:0] a;
    logic [15:0] d;
    bit wr = $urandom_range(0, 1) == 1;
    logic [31:0] c;
    if (s < 30)      a = 7'h00;
    else if (s < 40) a = 7'h7F;
    else if (s < 90) a = 7'($urandom_range(1, 6));
    else             a = 7'h40;
    case ($urandom_range(0, 4))
      0: d = 16'hA569;
      1: d = 16'h1248;
      2: d = 16'h0000;
      default: d = 16'($urandom());
    endcase
    c = mk(wr, a, d);
    if ($urandom_range(0, 99) < 8) c[23:16] = 8'($urandom_range(1, 255));
    return c;
  endfunction

  initial begin
    repeat (3000 * 64) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int i = 0; i < 128; i++) exp_mem[i] = '0;
    repeat (10) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset miso", {31'h0, spi_miso}, 32'h0);
    chk("R4 reset strobes", {30'h0, reg_we, reg_re}, 32'h0);

    // directed: locked state, key sequence, gated writes
    frame(mk(0, 7'h00, 16'h0), 32, 20);          // R4 read lock state
    frame(mk(1, 7'h05, 16'h1234), 32, 20);       // R3 locked write dropped
    frame(mk(0, 7'h05, 16'h0), 32, 3);           // R8 read back zero
    frame(mk(1, 7'h00, 16'hA569), 32, 3);        // R5
    frame(mk(0, 7'h00, 16'h0), 32, 3);           // expect 1
    frame(mk(1, 7'h00, 16'h1248), 32, 3);        // R6 open
    frame(mk(0, 7'h00, 16'h0), 32, 3);           // expect 3
    frame(mk(1, 7'h05, 16'hBEEF), 32, 3);        // R1 write passes
    frame(mk(0, 7'h05, 16'h0), 32, 3);           // R8 minimum gap read
    frame(mk(1, 7'h7F, 16'h0001), 32, 3);        // R7 write ignored
    frame(mk(0, 7'h7F, 16'h0), 32, 3);           // R7 revision
    frame({1'b1, 7'h05, 8'h10, 16'h1111}, 32, 10); // R2 reserved bits
    frame(mk(1, 7'h05, 16'h2222), 20, 10);       // R10 aborted frame
    frame(mk(0, 7'h05, 16'h0), 32, 3);           // still BEEF
    frame(mk(1, 7'h00, 16'hA569), 32, 3);        // R5 from open
    frame(mk(0, 7'h00, 16'h0), 32, 3);
    frame(mk(1, 7'h00, 16'h1248), 32, 3);
    frame(mk(1, 7'h00, 16'h0000), 32, 3);        // R6 relock
    frame(mk(1, 7'h06, 16'h7777), 32, 3);        // R3 dropped again
    frame(mk(1, 7'h00, 16'h1248), 32, 3);        // R6 second key alone
    frame(mk(0, 7'h00, 16'h0), 32, 3);           // expect 0
    frame(mk(1, 7'h00, 16'hA569), 32, 3);
    frame(mk(1, 7'h00, 16'h5555), 32, 3);        // R6 cancel
    frame(mk(0, 7'h00, 16'h0), 32, 12);          // expect 0
    frame(mk(0, 7'h06, 16'h0), 32, 12);

    // constrained random mix
    for (int n = 0; n < 140; n++) begin
      int nb = ($urandom_range(0, 99) < 5) ? $urandom_range(1, 31) : 32;
      int gp = ($urandom_range(0, 3) == 0) ? 3 : $urandom_range(3, 20);
      frame(rand_cmd(), nb, gp);
    end
    frame(mk(0, 7'h00, 16'h0), 32, 10);
    frame(mk(0, 7'h7F, 16'h0), 32, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule